// File: doc/BRIEF.md
# Block Transfer Port with Shared Staging Queue

This block sits between user logic and a word-addressed memory and moves one fixed-length block per request. The user logic raises a write request or a read request together with a start pointer. The pointer counts memory words, and each word is one 16-byte unit at the default width. A small round-robin arbiter grants one requester at a time and answers with a one-cycle acknowledge. The granted channel then owns the block until its transfer ends.

On a write, the user logic offers words qualified by a valid strobe. The words wait in a staging queue until the backend commits them at a fixed pace of one word per `WR_CYC` cycles. A full flag tells the user logic to pause, and the flag rises one entry early. A done pulse marks the last accepted word of the block.

On a read, the block fetches words from consecutive addresses into the same staging queue. It raises a ready flag while a word is available, and each cycle with the enable input high pops one word. A done pulse marks the last pop. Two status flags, one per direction, stay low while a transfer of that direction is active. Other agents check them before starting a new operation.

Top module: `blk_xfer_port`

## Requirements
- R1: After reset both acknowledges, `wr_full`, `wr_done`, `rd_rdy` and `rd_done` are 0, and `wr_free` and `rd_free` are 1.
- R2: A request sampled while both free flags are high is acknowledged in the next cycle. The acknowledge is high for exactly one cycle. The free flag of the granted direction is 0 in the acknowledge cycle and stays 0 until the transfer ends.
- R3: When both requests are high in the same idle cycle, the direction that was not granted last wins. If nothing has been granted since reset, the write wins. Only one acknowledge is high in any cycle.
- R4: A request made while a transfer of either direction is active gets no acknowledge.
- R5: A write word is taken only in a cycle where `wr_vld` is 1. The k-th accepted word (k counted from 0) is stored at address `(wr_ptr + k) mod 2**PTR_W`.
- R6: During a write, `wr_full` is 1 whenever the staging queue holds `FIFO_DEPTH-1` or more words. A word offered in the cycle after `wr_full` rises is still stored without loss.
- R7: `wr_done` is a one-cycle pulse that coincides with the `BLK_LEN`-th accepted word. Words offered after it in the same transfer are not stored.
- R8: `wr_free` stays 0 until every accepted word of the block has been committed to memory. It then returns to 1.
- R9: In a read transfer, `rd_rdy` is 1 exactly while a word is available. With `rd_rdy` high, `rd_data` shows the next word, and a cycle with `rd_en` high pops it. The words come from `rd_ptr`, `rd_ptr+1`, and so on.
- R10: `rd_done` is 1 in the cycle of the `BLK_LEN`-th pop. In the following cycle `rd_rdy` is 0 and `rd_free` is 1.
- R11: Block addresses wrap from the highest memory address to address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_req | input | 1 | Write transfer request |
| wr_ptr | input | PTR_W | Write start address in word units |
| wr_ack | output | 1 | One-cycle write grant |
| wr_vld | input | 1 | Write word valid |
| wr_data | input | DATA_W | Write word |
| wr_full | output | 1 | Pause request to the write source (early by one entry) |
| wr_done | output | 1 | Pulse with the last accepted write word |
| wr_free | output | 1 | No write transfer active |
| rd_req | input | 1 | Read transfer request |
| rd_ptr | input | PTR_W | Read start address in word units |
| rd_ack | output | 1 | One-cycle read grant |
| rd_rdy | output | 1 | A read word is available |
| rd_en | input | 1 | Pop one read word |
| rd_data | output | DATA_W | Read word at the head of the queue |
| rd_done | output | 1 | Pulse with the last pop of the block |
| rd_free | output | 1 | No read transfer active |

## Verification
The bench builds the block with a 16-word memory (`PTR_W`=4), 32-bit words, six-word blocks, a four-entry queue and a backend that commits one word every three cycles. Because the block is longer than the queue and the commit pace is slower than the input rate, a gap-free write drives the queue up to the full threshold. The bench's own write source reacts to full one cycle late, so it offers a word in the cycle after full rises. The small memory lets a block that starts at address 13 wrap past the top of the memory. A read that overlaps the next block shows whether surplus writes after the done pulse were stored.

// File: rtl/bxp_pkg.sv
package bxp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WR   = 2'd1,
    ST_RD   = 2'd2
  } xfer_st_e;
endpackage

// File: rtl/bxp_arb.sv
// Round-robin grant between the write and read requesters; grants only when idle.
module bxp_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic idle,
  input  logic wr_req,
  input  logic rd_req,
  output logic gnt_wr,
  output logic gnt_rd,
  output logic wr_ack,
  output logic rd_ack
);
  logic prio_wr_q, prio_wr_d;
  logic wr_ack_q, rd_ack_q;

  always_comb begin
    gnt_wr    = idle && wr_req && (!rd_req || prio_wr_q);
    gnt_rd    = idle && rd_req && (!wr_req || !prio_wr_q);
    prio_wr_d = prio_wr_q;
    if (gnt_wr) prio_wr_d = 1'b0;
    if (gnt_rd) prio_wr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio_wr_q <= 1'b1;
      wr_ack_q  <= 1'b0;
      rd_ack_q  <= 1'b0;
    end else begin
      prio_wr_q <= prio_wr_d;
      wr_ack_q  <= gnt_wr;
      rd_ack_q  <= gnt_rd;
    end
  end

  assign wr_ack = wr_ack_q;
  assign rd_ack = rd_ack_q;
endmodule

// File: rtl/bxp_fifo.sv
// Staging queue shared by both directions. DEPTH must be a power of two, at least 2.
module bxp_fifo #(
  parameter int W     = 128,
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [W-1:0]                 push_data,
  input  logic                         pop,
  output logic [W-1:0]                 head,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  store [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (push) wp_d = wp_q + AW'(1);
    if (pop)  rp_d = rp_q + AW'(1);
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + CW'(1);
      2'b01:   cnt_d = cnt_q - CW'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) store[wp_q] <= push_data;
  end

  assign head  = store[rp_q];
  assign count = cnt_q;
  assign empty = (cnt_q == '0);
endmodule

// File: rtl/bxp_mem.sv
// Single-port synchronous word memory, one-cycle read latency.
module bxp_mem #(
  parameter int W  = 128,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  localparam int WORDS = 1 << AW;

  logic [W-1:0] arr [WORDS];
  logic [W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we) arr[addr] <= wdata;
    rdata_q <= arr[addr];
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/blk_xfer_port.sv
module blk_xfer_port #(
  parameter int PTR_W      = 8,
  parameter int DATA_W     = 128,
  parameter int BLK_LEN    = 4,
  parameter int FIFO_DEPTH = 4,
  parameter int WR_CYC     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic [PTR_W-1:0]  wr_ptr,
  output logic              wr_ack,
  input  logic              wr_vld,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_full,
  output logic              wr_done,
  output logic              wr_free,
  input  logic              rd_req,
  input  logic [PTR_W-1:0]  rd_ptr,
  output logic              rd_ack,
  output logic              rd_rdy,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_done,
  output logic              rd_free
);
  import bxp_pkg::*;

  localparam int CNT_W  = $clog2(BLK_LEN + 1);
  localparam int FCNT_W = $clog2(FIFO_DEPTH + 1);
  localparam int PC_W   = $clog2(WR_CYC + 1);
  localparam logic [CNT_W-1:0]  BLK_N     = CNT_W'(BLK_LEN);
  localparam logic [CNT_W-1:0]  BLK_LAST  = CNT_W'(BLK_LEN - 1);
  localparam logic [FCNT_W-1:0] FULL_AT   = FCNT_W'(FIFO_DEPTH - 1);
  localparam logic [FCNT_W:0]   DEPTH_N   = (FCNT_W+1)'(FIFO_DEPTH);
  localparam logic [PC_W-1:0]   PC_RELOAD = PC_W'(WR_CYC - 1);

  // reset: asynchronous assert, synchronous release
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  xfer_st_e         st_q, st_d;
  logic [PTR_W-1:0] base_q, base_d;
  logic [CNT_W-1:0] in_q, in_d;     // words accepted (write) or fetches issued (read)
  logic [CNT_W-1:0] out_q, out_d;   // words committed (write) or popped (read)
  logic [PC_W-1:0]  pc_q, pc_d;     // backend pacing counter
  logic             infl_q, infl_d; // read fetch in flight

  logic gnt_wr, gnt_rd;
  logic accept, commit, issue, pop_rd;
  logic fifo_push, fifo_pop, fifo_empty;
  logic [FCNT_W-1:0] fifo_cnt;
  logic [DATA_W-1:0] fifo_in, fifo_head, mem_rdata;
  logic [PTR_W-1:0]  mem_addr;

  bxp_arb u_arb (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .idle   (st_q == ST_IDLE),
    .wr_req (wr_req),
    .rd_req (rd_req),
    .gnt_wr (gnt_wr),
    .gnt_rd (gnt_rd),
    .wr_ack (wr_ack),
    .rd_ack (rd_ack)
  );

  always_comb begin
    accept = (st_q == ST_WR) && wr_vld && (in_q != BLK_N);
    commit = (st_q == ST_WR) && !fifo_empty && (pc_q == '0);
    issue  = (st_q == ST_RD) && (in_q != BLK_N) &&
             (({1'b0, fifo_cnt} + {{FCNT_W{1'b0}}, infl_q}) < DEPTH_N);
    pop_rd = (st_q == ST_RD) && rd_en && !fifo_empty;
  end

  assign fifo_push = accept || infl_q;
  assign fifo_pop  = commit || pop_rd;
  assign fifo_in   = (st_q == ST_WR) ? wr_data : mem_rdata;
  assign mem_addr  = (st_q == ST_RD) ? (base_q + PTR_W'(in_q))
                                     : (base_q + PTR_W'(out_q));

  bxp_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .push      (fifo_push),
    .push_data (fifo_in),
    .pop       (fifo_pop),
    .head      (fifo_head),
    .count     (fifo_cnt),
    .empty     (fifo_empty)
  );

  bxp_mem #(.W(DATA_W), .AW(PTR_W)) u_mem (
    .clk   (clk),
    .we    (commit),
    .addr  (mem_addr),
    .wdata (fifo_head),
    .rdata (mem_rdata)
  );

  // next-state
  always_comb begin
    st_d   = st_q;
    base_d = base_q;
    in_d   = in_q;
    out_d  = out_q;
    pc_d   = pc_q;
    infl_d = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (gnt_wr || gnt_rd) begin
          st_d   = gnt_wr ? ST_WR : ST_RD;
          base_d = gnt_wr ? wr_ptr : rd_ptr;
          in_d   = '0;
          out_d  = '0;
          pc_d   = '0;
        end
      end
      ST_WR: begin
        if (accept) in_d = in_q + CNT_W'(1);
        if (commit) begin
          out_d = out_q + CNT_W'(1);
          pc_d  = PC_RELOAD;
          if (out_q == BLK_LAST) st_d = ST_IDLE;
        end else if (pc_q != '0) begin
          pc_d = pc_q - PC_W'(1);
        end
      end
      ST_RD: begin
        infl_d = issue;
        if (issue) in_d = in_q + CNT_W'(1);
        if (pop_rd) begin
          out_d = out_q + CNT_W'(1);
          if (out_q == BLK_LAST) st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      st_q   <= ST_IDLE;
      base_q <= '0;
      in_q   <= '0;
      out_q  <= '0;
      pc_q   <= '0;
      infl_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      base_q <= base_d;
      in_q   <= in_d;
      out_q  <= out_d;
      pc_q   <= pc_d;
      infl_q <= infl_d;
    end
  end

  assign wr_free = (st_q != ST_WR);
  assign rd_free = (st_q != ST_RD);
  assign wr_full = (st_q == ST_WR) && (fifo_cnt >= FULL_AT);
  assign wr_done = accept && (in_q == BLK_LAST);
  assign rd_rdy  = (st_q == ST_RD) && !fifo_empty;
  assign rd_data = fifo_head;
  assign rd_done = pop_rd && (out_q == BLK_LAST);
endmodule

// File: rtl/bxp_chk.sv
module bxp_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_ack,
  input logic rd_ack,
  input logic wr_full,
  input logic wr_done,
  input logic wr_free,
  input logic rd_rdy,
  input logic rd_done,
  input logic rd_free
);
  p_ack_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ack || rd_ack) |=> !(wr_ack || rd_ack));

  p_ack_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ack |-> !wr_free);

  p_single_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_ack && rd_ack));

  p_no_ack_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_free && rd_free) |=> !(wr_ack || rd_ack));

  p_full_in_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_full |-> !wr_free);

  p_wdone_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |=> !wr_done);

  p_rdy_in_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rdy |-> !rd_free);

  p_rdone_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> (rd_free && !rd_rdy));
endmodule

bind blk_xfer_port bxp_chk u_bxp_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_ack  (wr_ack),
  .rd_ack  (rd_ack),
  .wr_full (wr_full),
  .wr_done (wr_done),
  .wr_free (wr_free),
  .rd_rdy  (rd_rdy),
  .rd_done (rd_done),
  .rd_free (rd_free)
);

// File: tb/test_blk_xfer_port.sv
module test_blk_xfer_port;
  localparam int P  = 4;
  localparam int W  = 32;
  localparam int BL = 6;
  localparam int FD = 4;
  localparam int WC = 3;
  localparam int MW = 1 << P;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_req = 1'b0, rd_req = 1'b0, wr_vld = 1'b0, rd_en = 1'b0;
  logic [P-1:0] wr_ptr = '0, rd_ptr = '0;
  logic [W-1:0] wr_data = '0;
  logic wr_ack, wr_full, wr_done, wr_free, rd_ack, rd_rdy, rd_done, rd_free;
  logic [W-1:0] rd_data;

  always #10 clk = ~clk;

  blk_xfer_port #(.PTR_W(P), .DATA_W(W), .BLK_LEN(BL), .FIFO_DEPTH(FD), .WR_CYC(WC))
  i_blk_xfer_port (
    .clk(clk), .rst_n(rst_n),
    .wr_req(wr_req), .wr_ptr(wr_ptr), .wr_ack(wr_ack), .wr_vld(wr_vld),
    .wr_data(wr_data), .wr_full(wr_full), .wr_done(wr_done), .wr_free(wr_free),
    .rd_req(rd_req), .rd_ptr(rd_ptr), .rd_ack(rd_ack), .rd_rdy(rd_rdy),
    .rd_en(rd_en), .rd_data(rd_data), .rd_done(rd_done), .rd_free(rd_free)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int last_gnt = 0;          // 0 none, 1 write, 2 read
  int cyc = 0;
  bit saw_full = 0;
  bit rd_seen_done = 0;
  logic [W-1:0] mdl [MW];
  logic [W-1:0] exp_q [$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // request phase: returns 1 if the write was granted
  task automatic do_req(input bit w, input bit r, input logic [P-1:0] wp,
                        input logic [P-1:0] rp, output bit got_wr);
    bit exp_wr;
    exp_wr = w && (!r || last_gnt != 1);
    @(negedge clk);
    wr_req = w; rd_req = r; wr_ptr = wp; rd_ptr = rp;
    @(negedge clk);
    if (w && r) begin
      check(wr_ack == exp_wr && rd_ack == !exp_wr, "R3 tie winner", {wr_ack, rd_ack}, {exp_wr, !exp_wr});
    end else begin
      check((exp_wr ? wr_ack : rd_ack) == 1'b1, "R2 ack one cycle after request", 0, 1);
    end
    check((exp_wr ? wr_free : rd_free) == 1'b0, "R2 free flag low in ack cycle", 1, 0);
    wr_req = 1'b0; rd_req = 1'b0;
    @(negedge clk);
    check(!wr_ack && !rd_ack, "R2 ack single pulse", {wr_ack, rd_ack}, 0);
    got_wr = exp_wr;
    last_gnt = exp_wr ? 1 : 2;
  endtask

  task automatic wr_phase(input logic [P-1:0] ptr, input logic [W-1:0] seed,
                          input bit gaps, input int extra, input bit probe);
    int k = 0;
    bit full_d = 0;
    bit f;
    bit present;
    while (k < BL + extra) begin
      f = wr_full;
      if (f) saw_full = 1;
      present = !full_d && !(gaps && (cyc % 3 == 1));
      full_d = f;
      if (probe && k < 3) begin
        rd_req = 1'b1;
        check(rd_ack == 1'b0, "R4 no ack while busy", rd_ack, 0);
      end else begin
        rd_req = 1'b0;
      end
      if (present) begin
        wr_vld = 1'b1;
        wr_data = seed + W'(k);
        #1;
        check(wr_done == (k == BL - 1), "R7 done on last accepted word", wr_done, (k == BL - 1));
        if (k == BL - 1) check(wr_free == 1'b0, "R8 free low at done", wr_free, 0);
        if (k < BL) mdl[(int'(ptr) + k) % MW] = seed + W'(k);
        k++;
      end else begin
        wr_vld = 1'b0;
        wr_data = 32'hDEAD0000 + W'(cyc);
      end
      @(negedge clk);
    end
    wr_vld = 1'b0;
    rd_req = 1'b0;
    while (!wr_free) @(negedge clk);
    check(wr_free == 1'b1, "R8 free after commit", wr_free, 1);
  endtask

  task automatic fill_exp(input logic [P-1:0] ptr);
    for (int i = 0; i < BL; i++) exp_q.push_back(mdl[(int'(ptr) + i) % MW]);
  endtask

  task automatic rd_phase(input bit gaps);
    rd_seen_done = 0;
    while (!rd_seen_done) begin
      rd_en = gaps ? (cyc % 2 == 0) : 1'b1;
      @(negedge clk);
    end
    rd_en = 1'b0;
    check(rd_rdy == 1'b0 && rd_free == 1'b1, "R10 idle after last pop", {rd_rdy, rd_free}, 2'b01);
    check(exp_q.size() == 0, "R9 all words delivered", W'(exp_q.size()), 0);
  endtask

  // monitor: compares popped words against the scoreboard queue
  always @(negedge clk) begin
    #2;
    if (rst_n && rd_en && rd_rdy) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9 unexpected pop", rd_data, 0);
      end else begin
        logic [W-1:0] e;
        e = exp_q.pop_front();
        check(rd_data == e, "R9 read word", rd_data, e);
        check(rd_done == (exp_q.size() == 0), "R10 done on last pop", rd_done, (exp_q.size() == 0));
        if (rd_done) rd_seen_done = 1;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finish_run();
  end

  initial begin
    bit g;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1
    check(!wr_ack && !rd_ack, "R1 acks low", {wr_ack, rd_ack}, 0);
    check(!wr_full && !wr_done && !rd_rdy && !rd_done, "R1 outputs low",
          {wr_full, wr_done, rd_rdy, rd_done}, 0);
    check(wr_free && rd_free, "R1 free flags high", {wr_free, rd_free}, 2'b11);

    // block A at 0, gap-free, busy probe (R4, R6)
    do_req(1, 0, 4'd0, 4'd0, g);
    wr_phase(4'd0, 32'hA000, 0, 0, 1);
    check(saw_full == 1'b1, "R6 full seen on gap-free block", saw_full, 1);
    // block B at 6 with valid gaps (R5)
    do_req(1, 0, 4'd6, 4'd0, g);
    wr_phase(4'd6, 32'hB000, 1, 0, 0);
    // read A back with pop gaps (R5, R6, R9)
    fill_exp(4'd0);
    do_req(0, 1, 4'd0, 4'd0, g);
    rd_phase(1);
    // tie after read: write wins (R3); block C with two surplus words (R7)
    do_req(1, 1, 4'd0, 4'd3, g);
    check(g == 1'b1, "R3 write granted after read", g, 1);
    wr_phase(4'd0, 32'hC000, 0, 2, 0);
    // read from 1: C1..C5 then B0, surplus must not have landed at 6 (R7)
    fill_exp(4'd1);
    do_req(0, 1, 4'd0, 4'd1, g);
    rd_phase(0);
    // wrap write at 13 (R11)
    do_req(1, 0, 4'd13, 4'd0, g);
    wr_phase(4'd13, 32'hD000, 1, 0, 0);
    // tie after write: read wins (R3), read wraps (R11)
    fill_exp(4'd13);
    do_req(1, 1, 4'd2, 4'd13, g);
    check(g == 1'b0, "R3 read granted after write", g, 0);
    rd_phase(0);
    check(mdl[0] == 32'hD003, "R11 model wrap sanity", mdl[0], 32'hD003);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule